// File: doc/BRIEF.md
# Analog TV Horizontal Line Timer

This block produces the horizontal timing of one analog television line. A pixel-rate enable advances a pixel counter, which wraps after a programmed line total. From the counter position the block derives three gates: horizontal sync, horizontal blanking and the colorburst window. It also emits a one-cycle end-of-line strobe for a downstream vertical counter.

Software sets six timing values and a burst-enable bit through a small write port. The line total is programmed as pixels minus one. The burst and blanking positions are offsets, in pixels minus one, counted from the start of sync. Writes land in a shadow copy. The working copy takes the shadow at a line wrap, and on every clock while the block is stopped, so the timing of a line never changes while that line is being drawn.

Top module: `tv_hline_timer`

## Requirements
- R1: While `run` is low, `pix_cnt` becomes 0 at the next clock edge and stays there, and `hsync`, `hblank`, `burst` and `eol` are all low in the same cycle `run` is low; after reset every output is 0.
- R2: While `run` is high, `pix_cnt` increments by one on each clock edge with `pix_en` high and holds on edges with `pix_en` low.
- R3: With `run` and `pix_en` high and `pix_cnt` equal to the line total T, `eol` is high in that cycle and `pix_cnt` becomes 0 at the next edge, so a line lasts T+1 enabled pixels (T=0 gives `eol` on every enabled cycle).
- R4: `hsync` is high exactly while `pix_cnt` < S, where S is the sync width (S=0 gives no sync).
- R5: `burst` is high exactly while `pix_cnt` lies in B+1 .. B+L, where B is the burst start and L the burst length, and it stays low whenever the burst-enable bit is 0.
- R6: With P = blank start + 1 and Q = blank end + 1, `hblank` is high for P <= `pix_cnt` <= Q when P <= Q; when P > Q the window wraps past the line end, and `hblank` is high when `pix_cnt` >= P or `pix_cnt` <= Q.
- R7: A write with `wr_en` high stores `wr_data` into the shadow register picked by `wr_sel`, where 0 = line total, 1 = sync width, 2 = burst start, 3 = burst length, 4 = blank start, 5 = blank end, and 6 = burst enable (bit 0); select 7 is ignored. A write made in the middle of a line does not change the current line; the shadow is copied at the end-of-line edge, and on every edge while `run` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Block enable |
| pix_en | input | 1 | Pixel-rate advance strobe |
| wr_en | input | 1 | Shadow register write strobe |
| wr_sel | input | 3 | Shadow register select |
| wr_data | input | W (13) | Write value |
| pix_cnt | output | W (13) | Pixel position in the line |
| hsync | output | 1 | Horizontal sync gate |
| hblank | output | 1 | Horizontal blanking gate |
| burst | output | 1 | Colorburst gate |
| eol | output | 1 | End-of-line strobe |

## Verification
A bench model steps every pixel of several line setups and compares each output in every cycle. The pixel enable pattern is irregular, which separates counting on enabled cycles from counting on every clock. The setups include:
- a blanking window that ends exactly on the line total;
- windows that wrap, one starting after the last pixel;
- a one-pixel line;
- a long line whose burst sits inside a wrapping blank.

Mid-line rewrites of the total and the windows show whether the new values reach the current line or only the next one. Turning the burst enable off shows that it masks the window.

// File: rtl/tv_hline_timer.sv
module tv_hline_timer #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         pix_en,
  input  logic         wr_en,
  input  logic [2:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] pix_cnt,
  output logic         hsync,
  output logic         hblank,
  output logic         burst,
  output logic         eol
);

  localparam logic [2:0] SEL_TOTAL = 3'd0;
  localparam logic [2:0] SEL_SYNC  = 3'd1;
  localparam logic [2:0] SEL_BST   = 3'd2;
  localparam logic [2:0] SEL_BLEN  = 3'd3;
  localparam logic [2:0] SEL_HBS   = 3'd4;
  localparam logic [2:0] SEL_HBE   = 3'd5;
  localparam logic [2:0] SEL_BON   = 3'd6;

  logic [W-1:0] s_total, s_sync, s_bst, s_blen, s_hbs, s_hbe;
  logic         s_bon;
  logic [W-1:0] a_total, a_sync, a_bst, a_blen, a_hbs, a_hbe;
  logic         a_bon;
  logic [W-1:0] cnt;

  wire wrap = run & pix_en & (cnt == a_total);
  wire load = ~run | wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {s_total, s_sync, s_bst, s_blen, s_hbs, s_hbe, s_bon} <= '0;
      {a_total, a_sync, a_bst, a_blen, a_hbs, a_hbe, a_bon} <= '0;
      cnt <= '0;
    end else begin
      if (wr_en) begin
        case (wr_sel)
          SEL_TOTAL: s_total <= wr_data;
          SEL_SYNC:  s_sync  <= wr_data;
          SEL_BST:   s_bst   <= wr_data;
          SEL_BLEN:  s_blen  <= wr_data;
          SEL_HBS:   s_hbs   <= wr_data;
          SEL_HBE:   s_hbe   <= wr_data;
          SEL_BON:   s_bon   <= wr_data[0];
          default: ;
        endcase
      end
      if (load) begin
        a_total <= s_total;
        a_sync  <= s_sync;
        a_bst   <= s_bst;
        a_blen  <= s_blen;
        a_hbs   <= s_hbs;
        a_hbe   <= s_hbe;
        a_bon   <= s_bon;
      end
      if (!run)        cnt <= '0;
      else if (pix_en) cnt <= wrap ? '0 : cnt + 1'b1;
    end
  end

  wire [W:0] c     = {1'b0, cnt};
  wire [W:0] b_lo  = {1'b0, a_bst};
  wire [W:0] b_hi  = b_lo + {1'b0, a_blen};
  wire [W:0] hb_s  = {1'b0, a_hbs} + 1'b1;
  wire [W:0] hb_e  = {1'b0, a_hbe} + 1'b1;

  wire in_burst = (c > b_lo) && (c <= b_hi);
  wire in_blank = (hb_s <= hb_e) ? ((c >= hb_s) && (c <= hb_e))
                                 : ((c >= hb_s) || (c <= hb_e));

  assign pix_cnt = cnt;
  assign eol     = wrap;
  assign hsync   = run & (cnt < a_sync);
  assign burst   = run & a_bon & in_burst;
  assign hblank  = run & in_blank;

endmodule

// File: rtl/tv_hline_timer_chk.sv
module tv_hline_timer_chk #(
  parameter int W = 13
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run,
  input logic         pix_en,
  input logic [W-1:0] pix_cnt,
  input logic         hsync,
  input logic         hblank,
  input logic         burst,
  input logic         eol
);

  a_r1_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> pix_cnt == '0);

  a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !(hsync || hblank || burst || eol));

  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pix_en && !eol) |=> pix_cnt == $past(pix_cnt) + 1'b1);

  a_r2_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !pix_en) |=> $stable(pix_cnt));

  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    eol |=> pix_cnt == '0);

  a_r3_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    eol |-> (run && pix_en));

endmodule

bind tv_hline_timer tv_hline_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .pix_en(pix_en), .pix_cnt(pix_cnt),
  .hsync(hsync), .hblank(hblank), .burst(burst), .eol(eol)
);

// File: tb/tv_hline_timer_test.sv
module tv_hline_timer_test;
  localparam int W = 13;

  logic clk = 0, rst_n = 0, run = 0, pix_en = 0, wr_en = 0;
  logic [2:0]   wr_sel = '0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] pix_cnt;
  logic hsync, hblank, burst, eol;

  tv_hline_timer #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .run(run), .pix_en(pix_en), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .pix_cnt(pix_cnt), .hsync(hsync),
    .hblank(hblank), .burst(burst), .eol(eol)
  );

  always #2 clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 0;
  string ctx = "reset";
  int sh[7];
  int ac[7];
  int cnt = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s (%s) cnt=%0d: actual=%0d expected=%0d", tag, ctx, cnt, act, exp);
    end
  endtask

  task automatic wr(input int sel, input int val);
    @(negedge clk);
    pix_en = 0; wr_en = 1; wr_sel = 3'(sel); wr_data = W'(val);
    @(posedge clk); #1;
    wr_en = 0;
    if (sel < 7) sh[sel] = (sel == 6) ? (val & 1) : val;
  endtask

  task automatic cfg(input int t, input int s, input int bs, input int bl,
                     input int hs, input int he, input int bon);
    wr(0, t); wr(1, s); wr(2, bs); wr(3, bl); wr(4, hs); wr(5, he); wr(6, bon);
  endtask

  task automatic step(input bit r, input bit en);
    int p, q;
    bit eb, ehb;
    @(negedge clk);
    run = r; pix_en = en; #1;
    p = ac[4] + 1; q = ac[5] + 1;
    eb = r && ac[6] != 0 && cnt > ac[2] && cnt <= ac[2] + ac[3];
    ehb = r && ((p <= q) ? (cnt >= p && cnt <= q) : (cnt >= p || cnt <= q));
    chk(r ? "R2" : "R1", int'(pix_cnt), cnt);
    chk(r ? "R3" : "R1", int'(eol), int'(r && en && cnt == ac[0]));
    chk(r ? "R4" : "R1", int'(hsync), int'(r && cnt < ac[1]));
    chk(r ? "R5" : "R1", int'(burst), int'(eb));
    chk(r ? "R6" : "R1", int'(hblank), int'(ehb));
    if (!r) begin
      cnt = 0; ac = sh;
    end else if (en) begin
      if (cnt == ac[0]) begin cnt = 0; ac = sh; end
      else cnt++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 7; i++) begin sh[i] = 0; ac[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    ctx = "R1 reset state";
    step(0, 1);

    ctx = "R4 R5 R6 blank ends at total";
    cfg(9, 2, 3, 2, 6, 8, 1);
    step(0, 0);
    for (int i = 0; i < 40; i++) step(1, (i % 3) != 0);

    ctx = "R7 mid-line rewrite, R6 wrapping blank, R5 burst off";
    while (cnt != 4) step(1, 1);
    wr(0, 12); wr(4, 7); wr(5, 0); wr(6, 0);
    for (int i = 0; i < 45; i++) step(1, (i % 4) != 1);

    ctx = "R1 stop";
    for (int i = 0; i < 3; i++) step(0, 1);

    ctx = "R6 blank starts past total";
    cfg(9, 1, 0, 3, 9, 2, 1);
    step(0, 0);
    for (int i = 0; i < 30; i++) step(1, 1);

    ctx = "R3 one-pixel line";
    step(0, 0);
    cfg(0, 1, 0, 0, 0, 0, 1);
    step(0, 0);
    for (int i = 0; i < 6; i++) step(1, i != 2);

    ctx = "R7 select 7 ignored, long line R5 R6";
    step(0, 0);
    cfg(300, 20, 30, 9, 250, 40, 1);
    wr(7, 5);
    step(0, 0);
    for (int i = 0; i < 700; i++) step(1, 1);

    ctx = "R1 final stop";
    step(0, 1);
    step(0, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule